// File: doc/BRIEF.md
# Invert-and-Select Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit of parameterised width. Six functions come from one shared structure, not from a case table of opcodes. Each operand can first be bit-inverted. One adder and one bitwise AND/OR stage then work on the conditioned operands. A two-bit selector picks the AND, OR, sum or signed-less-than result.

- Subtraction is the add path with B inverted and a carry-in of one.
- NOR is the AND path with both operands inverted.
- Set-less-than is derived from the subtraction's sign bit corrected by its overflow.

The unit also drives a zero flag, high when every result bit is clear. It drives a signed-overflow flag taken from the adder. The default width is 4 bits, and the same code is used at 32 bits. There is no state, no clock and no reset.

Top module: `inv_sel_alu`

## Requirements
- R1: Control word 4'b0000 gives result = A AND B. The control word is decoded as follows: bit 3 inverts A, bit 2 inverts B, and bits 1:0 select the function (00 AND, 01 OR, 10 sum, 11 less-than).
- R2: Control word 4'b0001 gives result = A OR B.
- R3: Control word 4'b0010 gives result = (A + B) modulo 2^W.
- R4: Control word 4'b0110 gives result = (A - B) modulo 2^W, formed as A + ~B + 1.
- R5: Control word 4'b0111 gives a result of 1 in bit 0, with all other bits zero, when A < B as signed two's-complement numbers. Otherwise the result is zero.
- R6: Control word 4'b1100 gives result = NOT (A OR B).
- R7: zero_flag is 1 exactly when every result bit is 0, for every control word.
- R8: For control word 4'b0010, ovf_flag is 1 exactly when the signed sum A + B falls outside the W-bit signed range.
- R9: For control word 4'b0110, ovf_flag is 1 exactly when the signed difference A - B falls outside the W-bit signed range.
- R10: At W = 32 the functions and flags of R1 to R9 hold unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| ctrl | input | 4 | Control word: invert-A, invert-B, function select[1:0] |
| result | output | W | Function result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow of the adder, meaningful for sum and difference |

## Verification
The hardest case to reach from the ports is a set-less-than where the subtraction itself overflows. Here the raw sign bit gives the wrong answer, and only the overflow correction makes the result right. At 4 bits the stimulus reaches every such pair by sweeping all 256 operand pairs for each listed control word. At 32 bits, random operands with forced sign mixes push into both overflow directions. The same sweep also covers equal operands, which must give a zero difference, a zero flag and a clear less-than.

// File: rtl/inv_sel_alu_pkg.sv
// Package: shared control-word types for the invert-and-select ALU.
// Assumes the control word is packed as {inv_a, inv_b, sel[1:0]}.
package inv_sel_alu_pkg;

    // Function selector applied after operand conditioning
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } fn_sel_e;

    // Decoded view of the 4-bit control word
    typedef struct packed {
        logic    inv_a;
        logic    inv_b;
        fn_sel_e sel;
    } alu_ctrl_t;

    localparam int CTRL_W = $bits(alu_ctrl_t);

endpackage

// File: rtl/alu_operand_cond.sv
// Module: conditionally inverts one operand bitwise.
// Assumes inv is stable for the evaluation; purely combinational.
module alu_operand_cond #(
    parameter int W = 4
) (
    input  logic [W-1:0] raw,
    input  logic         inv,
    output logic [W-1:0] cond
);

    // Apply the optional inversion
    always_comb begin
        cond = inv ? ~raw : raw;
    end

endmodule

// File: rtl/alu_adder_unit.sv
// Module: adds two conditioned operands plus a carry-in and reports the
// signed overflow and the signed less-than decision taken from the sum.
// Assumes two's-complement operands of width W >= 2.
module alu_adder_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         less
);

    localparam int MSB = W - 1;

    // Form the W-bit sum; the carry-out is not needed
    always_comb begin
        sum = x + y + {{(W-1){1'b0}}, cin};
    end

    // Overflow: equal input signs with a differing sum sign
    always_comb begin
        ovf = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

    // Less-than: sign of the difference corrected by overflow
    always_comb begin
        less = sum[MSB] ^ ovf;
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise AND and OR of the conditioned operands.
// Assumes nothing beyond equal operand widths.
module alu_logic_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] and_out,
    output logic [W-1:0] or_out
);

    // Produce both bitwise results in parallel
    always_comb begin
        and_out = x & y;
        or_out  = x | y;
    end

endmodule

// File: rtl/alu_result_sel.sv
// Module: picks the final result from the function selector and forms the
// zero flag. Assumes the less-than bit lands in bit 0 only.
module alu_result_sel
    import inv_sel_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  fn_sel_e      sel,
    input  logic [W-1:0] and_in,
    input  logic [W-1:0] or_in,
    input  logic [W-1:0] sum_in,
    input  logic         less_in,
    output logic [W-1:0] res,
    output logic         zero
);

    // Select one of the four function outputs
    always_comb begin
        unique case (sel)
            SEL_AND:  res = and_in;
            SEL_OR:   res = or_in;
            SEL_SUM:  res = sum_in;
            SEL_LESS: res = {{(W-1){1'b0}}, less_in};
            default:  res = '0;
        endcase
    end

    // Zero flag: no result bit set
    always_comb begin
        zero = ~|res;
    end

endmodule

// File: rtl/inv_sel_alu.sv
// Module: top of the invert-and-select ALU. Conditions both operands,
// runs the adder and the logic unit in parallel, and selects a result.
// Assumes W >= 2; combinational only, so no clock or reset is present.
module inv_sel_alu
    import inv_sel_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [W-1:0]      result,
    output logic              zero_flag,
    output logic              ovf_flag
);

    alu_ctrl_t   cw;
    logic [W-1:0] cond_ops [2];
    logic [W-1:0] raw_ops  [2];
    logic [1:0]   inv_bits;
    logic [W-1:0] sum_w, and_w, or_w;
    logic         less_w;

    // Decode the control word and gather operands for the conditioning stage
    always_comb begin
        cw          = alu_ctrl_t'(ctrl);
        raw_ops[0]  = op_a;
        raw_ops[1]  = op_b;
        inv_bits[0] = cw.inv_a;
        inv_bits[1] = cw.inv_b;
    end

    for (genvar i = 0; i < 2; i++) begin : g_cond
        alu_operand_cond #(.W(W)) u_cond (
            .raw  (raw_ops[i]),
            .inv  (inv_bits[i]),
            .cond (cond_ops[i])
        );
    end

    // Carry-in follows invert-B so that inverted B plus one negates it
    alu_adder_unit #(.W(W)) u_add (
        .x    (cond_ops[0]),
        .y    (cond_ops[1]),
        .cin  (cw.inv_b),
        .sum  (sum_w),
        .ovf  (ovf_flag),
        .less (less_w)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .x       (cond_ops[0]),
        .y       (cond_ops[1]),
        .and_out (and_w),
        .or_out  (or_w)
    );

    alu_result_sel #(.W(W)) u_sel (
        .sel     (cw.sel),
        .and_in  (and_w),
        .or_in   (or_w),
        .sum_in  (sum_w),
        .less_in (less_w),
        .res     (result),
        .zero    (zero_flag)
    );

endmodule

// File: rtl/inv_sel_alu_chk.sv
// Checker: cross-relations between the ALU ports for the listed control
// words. Skips any evaluation while inputs are unknown.
module inv_sel_alu_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [3:0]   ctrl,
    input logic [W-1:0] result,
    input logic         zero_flag,
    input logic         ovf_flag
);

    // Evaluate port relations whenever the inputs are known
    always_comb begin
        if (!$isunknown({op_a, op_b, ctrl})) begin
            if (ctrl == 4'b0000)
                assert_and_subset_R1: assert ((result & ~op_a) == '0 && (result & ~op_b) == '0);
            if (ctrl == 4'b0001)
                assert_or_superset_R2: assert ((op_a & ~result) == '0 && (op_b & ~result) == '0);
            if (ctrl == 4'b0010 && op_a[W-1] != op_b[W-1])
                assert_no_overflow_R8: assert (!ovf_flag);
            if (ctrl == 4'b0110 && op_a == op_b)
                assert_equal_diff_R9: assert (zero_flag && !ovf_flag);
            if (ctrl == 4'b0111)
                assert_less_upper_R5: assert (result[W-1:1] == '0);
            if (ctrl == 4'b0111 && op_a == op_b)
                assert_less_equal_R5: assert (result == '0);
            if (ctrl == 4'b1100)
                assert_nor_disjoint_R6: assert ((result & op_a) == '0 && (result & op_b) == '0);
        end
    end

endmodule

bind inv_sel_alu inv_sel_alu_chk #(.W(W)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .ctrl      (ctrl),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
);

// File: tb/tb_inv_sel_alu.sv
// Bench: behavioural reference model evaluated every clock, exhaustive at
// 4 bits and random at 32 bits.
module tb_inv_sel_alu;

    localparam int CLK_PERIOD = 10;
    localparam int W_NARROW   = 4;
    localparam int W_WIDE     = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_failed = 0;
    bit   done = 1'b0;

    logic [W_NARROW-1:0] a4, b4, r4;
    logic [W_WIDE-1:0]   a32, b32, r32;
    logic [3:0]          c4, c32;
    logic                z4, v4, z32, v32;

    always #(CLK_PERIOD/2) clk = ~clk;

    inv_sel_alu #(.W(W_NARROW)) dut (
        .op_a(a4), .op_b(b4), .ctrl(c4),
        .result(r4), .zero_flag(z4), .ovf_flag(v4)
    );

    inv_sel_alu #(.W(W_WIDE)) dut_wide (
        .op_a(a32), .op_b(b32), .ctrl(c32),
        .result(r32), .zero_flag(z32), .ovf_flag(v32)
    );

    // Reference model built on signed integer arithmetic
    task automatic ref_eval(input int w, input logic [31:0] a, input logic [31:0] b,
                            input logic [3:0] c, output logic [31:0] r, output bit ov);
        longint mask = (64'sd1 <<< w) - 1;
        longint lo   = -(64'sd1 <<< (w - 1));
        longint hi   = (64'sd1 <<< (w - 1)) - 1;
        longint sa   = longint'(a) & mask;
        longint sb   = longint'(b) & mask;
        longint t;
        if (sa > hi) sa = sa - (mask + 1);
        if (sb > hi) sb = sb - (mask + 1);
        ov = 1'b0;
        r  = '0;
        case (c)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b0010: begin t = sa + sb; r = 32'(t & mask); ov = (t > hi) || (t < lo); end
            4'b0110: begin t = sa - sb; r = 32'(t & mask); ov = (t > hi) || (t < lo); end
            4'b0111: r = (sa < sb) ? 32'd1 : 32'd0;
            4'b1100: r = 32'(~(longint'(a | b)) & mask);
            default: r = '0;
        endcase
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare one DUT output set against the model
    task automatic compare(input int w, input logic [31:0] a, input logic [31:0] b,
                           input logic [3:0] c, input logic [31:0] r,
                           input logic z, input logic v, input string pfx);
        logic [31:0] er;
        bit ev;
        ref_eval(w, a, b, c, er, ev);
        check({pfx, tag_of(c)}, r, er);
        check({pfx, "R7 zero"}, {31'd0, z}, {31'd0, er == 0});
        if (c == 4'b0010) check({pfx, "R8 ovf"}, {31'd0, v}, {31'd0, ev});
        if (c == 4'b0110) check({pfx, "R9 ovf"}, {31'd0, v}, {31'd0, ev});
    endtask

    // Watchdog ends a hung run as a failure
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_failed++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_failed);
            $finish;
        end
    end

    initial begin
        logic [3:0] codes [6];
        codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0010;
        codes[3] = 4'b0110; codes[4] = 4'b0111; codes[5] = 4'b1100;
        a4 = '0; b4 = '0; c4 = '0; a32 = '0; b32 = '0; c32 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // Reset-state pattern: zero operands with AND give zero and flag set (R1, R7)
        check("R1 reset result", {28'd0, r4}, 32'd0);
        check("R7 reset zero", {31'd0, z4}, 32'd1);

        // Exhaustive 4-bit sweep of every listed code (R1-to-R9 via compare)
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                c4 = codes[k]; a4 = 4'(i >> 4); b4 = 4'(i);
                #1;
                compare(W_NARROW, {28'd0, a4}, {28'd0, b4}, c4, {28'd0, r4}, z4, v4, "");
            end
        end

        // Random 32-bit operands with forced sign mixes (R10)
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                c32 = codes[k];
                a32 = $urandom; b32 = $urandom;
                case (i % 5)
                    0: begin a32[31] = 1'b0; b32[31] = 1'b0; end
                    1: begin a32[31] = 1'b1; b32[31] = 1'b1; end
                    2: begin a32[31] = 1'b0; b32[31] = 1'b1; end
                    3: b32 = a32;
                    default: ;
                endcase
                #1;
                compare(W_WIDE, a32, b32, c32, r32, z32, v32, "R10 ");
            end
        end

        // 32-bit boundary: most negative minus one overflows, less-than holds (R10)
        @(negedge clk);
        c32 = 4'b0110; a32 = 32'h8000_0000; b32 = 32'h0000_0001; #1;
        compare(W_WIDE, a32, b32, c32, r32, z32, v32, "R10 ");
        @(negedge clk);
        c32 = 4'b0111; #1;
        compare(W_WIDE, a32, b32, c32, r32, z32, v32, "R10 ");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_failed);
        $finish;
    end

endmodule